// File: doc/BRIEF.md
# Gradient Test Pattern Generator

This block is a video test source that sits beside the pixel pipeline and, when enabled, replaces the incoming pixel stream with a synthetic pattern. Each active pixel gets a 16-bit pattern value. The value is built from a programmable start value, a horizontal increment added once per horizontal step period, and a vertical increment added once per vertical step period. Each axis also has its own mode: plain gradient, inversion on alternate step periods, or thin lines at the start of each step period. Each axis can restart its pattern at the middle of the active area, which shows the pattern twice side by side or twice stacked.

The block uses the same strobes as the timing generator that feeds it: DE for active pixels, a one-cycle line-start strobe and a one-cycle frame-start strobe. Each of the three output colour channels takes either the top eight bits of the pattern value or one of three fixed levels. When the pattern is disabled, the input video passes through. The output is registered, so every result appears one clock after the inputs that produced it.

Top module: `grad_pattern_gen`

## Requirements
- R1: While rst_ni is low, rgb_o is 0x000000.
- R2: With pg_en_i low, rgb_o equals the vid_i value sampled one clock earlier, whatever the other inputs are.
- R3: With pg_en_i high, a cycle with de_i low gives rgb_o = 0x000000 one clock later.
- R4: In gradient mode on both axes, an active pixel at pattern coordinates (xe, ye) has the value init_i + floor(xe/(hstep_i+1))*hinc_i + floor(ye/(vstep_i+1))*vinc_i modulo 2^16. A channel in pattern mode shows bits [15:8] of that value.
- R5: x is the number of de_i cycles since the last line_start_i or frame_start_i. When repeat is off, xe = x.
- R6: y starts at 0 on frame_start_i. y rises by one at each line_start_i that follows at least one de_i cycle since the previous line or frame strobe, so a line with no DE is not counted. When repeat is off, ye = y.
- R7: Mode code 1 (inversion) on an axis complements the value when that axis' step-period index is odd. If both axes invert at once, the two complements cancel.
- R8: Mode codes 2 and 3 (line) force the value to 0xFFFF when any line-mode axis is at the first pixel or line of a step period, and to 0x0000 otherwise. Line mode takes priority over gradient and inversion.
- R9: With hrep2_i set, xe = x - floor(act_w_i/2) for x >= floor(act_w_i/2). With vrep2_i set, ye = y - floor(act_h_i/2) for y >= floor(act_h_i/2). In both cases the step phase and increments restart from zero at that point.
- R10: Channel select codes: 0 selects the pattern, 1 selects 0x00, 2 selects 0x80, 3 selects 0xFF. R is rgb_o[23:16] (sel_r_i), G is [15:8] (sel_g_i) and B is [7:0] (sel_b_i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pg_en_i | input | 1 | 1: pattern output, 0: pass-through |
| de_i | input | 1 | Active pixel strobe |
| line_start_i | input | 1 | One-cycle strobe at each line start |
| frame_start_i | input | 1 | One-cycle strobe at each frame start |
| vid_i | input | 24 | Input video pixel |
| init_i | input | 16 | Pattern value at the top-left pixel |
| hinc_i | input | 16 | Horizontal increment |
| vinc_i | input | 16 | Vertical increment |
| hstep_i | input | 8 | Horizontal step length minus one |
| vstep_i | input | 8 | Vertical step length minus one |
| hmode_i | input | 2 | Horizontal mode: 0 gradient, 1 inversion, 2/3 line |
| vmode_i | input | 2 | Vertical mode: 0 gradient, 1 inversion, 2/3 line |
| hrep2_i | input | 1 | Repeat the pattern twice across the width |
| vrep2_i | input | 1 | Repeat the pattern twice down the height |
| act_w_i | input | 12 | Active width in pixels |
| act_h_i | input | 12 | Active height in lines |
| sel_r_i | input | 2 | Red channel source |
| sel_g_i | input | 2 | Green channel source |
| sel_b_i | input | 2 | Blue channel source |
| rgb_o | output | 24 | Registered output pixel |

## Verification
The checker tests the rules that depend only on the inputs of the previous clock, on every cycle: pass-through when disabled, black during blanking, the three fixed channel levels, and the two-level output of line mode. The pattern arithmetic needs the pixel and line history to check. This covers step counting, the odd-period inversion, the midpoint restart, and skipping lines that have no DE. Only the bench's frame scenarios show these, and there each output is compared against a coordinate-based model on every clock.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    AX_GRAD  = 2'd0,
    AX_INV   = 2'd1,
    AX_LINE0 = 2'd2,
    AX_LINE1 = 2'd3
  } ax_mode_e;

  typedef enum logic [1:0] {
    CH_PAT  = 2'd0,
    CH_ZERO = 2'd1,
    CH_MID  = 2'd2,
    CH_FULL = 2'd3
  } ch_sel_e;
endpackage

// File: rtl/pg_axis.sv
// One pattern axis: step phase, period parity and accumulated increment.
module pg_axis #(
  parameter int POS_W  = 12,
  parameter int STEP_W = 8,
  parameter int VAL_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [VAL_W-1:0]  inc_i,
  input  logic              rep2_i,
  input  logic [POS_W-1:0]  span_i,
  output logic [VAL_W-1:0]  acc_o,
  output logic              odd_o,
  output logic              first_o
);
  logic [POS_W-1:0]  pos_q;
  logic [STEP_W-1:0] cnt_q;
  logic [POS_W-1:0]  pos_nxt;
  logic [POS_W-1:0]  half;

  assign pos_nxt = pos_q + 1'b1;
  assign half    = span_i >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      cnt_q <= '0;
      odd_o <= 1'b0;
      acc_o <= '0;
    end else if (restart_i) begin
      pos_q <= '0;
      cnt_q <= '0;
      odd_o <= 1'b0;
      acc_o <= '0;
    end else if (adv_i) begin
      pos_q <= pos_nxt;
      if (rep2_i && pos_nxt == half) begin
        cnt_q <= '0;
        odd_o <= 1'b0;
        acc_o <= '0;
      end else if (cnt_q == step_i) begin
        cnt_q <= '0;
        odd_o <= ~odd_o;
        acc_o <= acc_o + inc_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign first_o = (cnt_q == '0);
endmodule

// File: rtl/pg_shade.sv
// Combines both axes into the pattern value and maps the three channels.
module pg_shade
  import pg_pkg::*;
#(
  parameter int VAL_W = 16,
  parameter int CH_W  = 8,
  localparam int NCH  = 3
) (
  input  logic [VAL_W-1:0]    base_i,
  input  logic [VAL_W-1:0]    hacc_i,
  input  logic [VAL_W-1:0]    vacc_i,
  input  logic                hodd_i,
  input  logic                vodd_i,
  input  logic                hfirst_i,
  input  logic                vfirst_i,
  input  logic [1:0]          hmode_i,
  input  logic [1:0]          vmode_i,
  input  logic [NCH-1:0][1:0] sel_i,
  output logic [NCH*CH_W-1:0] pix_o
);
  logic [VAL_W-1:0] val;
  logic             hline, vline, flip;

  assign hline = (ax_mode_e'(hmode_i) == AX_LINE0) || (ax_mode_e'(hmode_i) == AX_LINE1);
  assign vline = (ax_mode_e'(vmode_i) == AX_LINE0) || (ax_mode_e'(vmode_i) == AX_LINE1);
  assign flip  = ((ax_mode_e'(hmode_i) == AX_INV) & hodd_i) ^
                 ((ax_mode_e'(vmode_i) == AX_INV) & vodd_i);

  always_comb begin
    if (hline || vline)
      val = ((hline & hfirst_i) | (vline & vfirst_i)) ? '1 : '0;
    else
      val = (base_i + vacc_i + hacc_i) ^ {VAL_W{flip}};
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      unique case (ch_sel_e'(sel_i[c]))
        CH_PAT:  pix_o[c*CH_W +: CH_W] = val[VAL_W-1 -: CH_W];
        CH_ZERO: pix_o[c*CH_W +: CH_W] = '0;
        CH_MID:  pix_o[c*CH_W +: CH_W] = {1'b1, {(CH_W-1){1'b0}}};
        default: pix_o[c*CH_W +: CH_W] = '1;
      endcase
    end
  end
endmodule

// File: rtl/grad_pattern_gen.sv
module grad_pattern_gen #(
  parameter int VAL_W  = 16,
  parameter int STEP_W = 8,
  parameter int POS_W  = 12,
  parameter int CH_W   = 8,
  localparam int PIX_W = 3 * CH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pg_en_i,
  input  logic             de_i,
  input  logic             line_start_i,
  input  logic             frame_start_i,
  input  logic [PIX_W-1:0] vid_i,
  input  logic [VAL_W-1:0] init_i,
  input  logic [VAL_W-1:0] hinc_i,
  input  logic [VAL_W-1:0] vinc_i,
  input  logic [STEP_W-1:0] hstep_i,
  input  logic [STEP_W-1:0] vstep_i,
  input  logic [1:0]       hmode_i,
  input  logic [1:0]       vmode_i,
  input  logic             hrep2_i,
  input  logic             vrep2_i,
  input  logic [POS_W-1:0] act_w_i,
  input  logic [POS_W-1:0] act_h_i,
  input  logic [1:0]       sel_r_i,
  input  logic [1:0]       sel_g_i,
  input  logic [1:0]       sel_b_i,
  output logic [PIX_W-1:0] rgb_o
);
  logic [VAL_W-1:0] hacc, vacc;
  logic             hodd, vodd, hfirst, vfirst;
  logic             had_de_q;
  logic [PIX_W-1:0] pat_pix, rgb_d;

  // a line only counts vertically once it carried DE
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            had_de_q <= 1'b0;
    else if (frame_start_i || line_start_i) had_de_q <= 1'b0;
    else if (de_i)                          had_de_q <= 1'b1;
  end

  pg_axis #(.POS_W(POS_W), .STEP_W(STEP_W), .VAL_W(VAL_W)) u_hax (
    .clk_i, .rst_ni,
    .restart_i (frame_start_i | line_start_i),
    .adv_i     (de_i),
    .step_i    (hstep_i),
    .inc_i     (hinc_i),
    .rep2_i    (hrep2_i),
    .span_i    (act_w_i),
    .acc_o     (hacc),
    .odd_o     (hodd),
    .first_o   (hfirst)
  );

  pg_axis #(.POS_W(POS_W), .STEP_W(STEP_W), .VAL_W(VAL_W)) u_vax (
    .clk_i, .rst_ni,
    .restart_i (frame_start_i),
    .adv_i     (line_start_i & had_de_q),
    .step_i    (vstep_i),
    .inc_i     (vinc_i),
    .rep2_i    (vrep2_i),
    .span_i    (act_h_i),
    .acc_o     (vacc),
    .odd_o     (vodd),
    .first_o   (vfirst)
  );

  pg_shade #(.VAL_W(VAL_W), .CH_W(CH_W)) u_shade (
    .base_i   (init_i),
    .hacc_i   (hacc),
    .vacc_i   (vacc),
    .hodd_i   (hodd),
    .vodd_i   (vodd),
    .hfirst_i (hfirst),
    .vfirst_i (vfirst),
    .hmode_i  (hmode_i),
    .vmode_i  (vmode_i),
    .sel_i    ({sel_r_i, sel_g_i, sel_b_i}),
    .pix_o    (pat_pix)
  );

  assign rgb_d = !pg_en_i ? vid_i : (de_i ? pat_pix : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_o <= '0;
    else         rgb_o <= rgb_d;
  end
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
  parameter int CH_W   = 8,
  localparam int PIX_W = 3 * CH_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pg_en_i,
  input logic             de_i,
  input logic [PIX_W-1:0] vid_i,
  input logic [1:0]       hmode_i,
  input logic [1:0]       sel_r_i,
  input logic [1:0]       sel_g_i,
  input logic [1:0]       sel_b_i,
  input logic [PIX_W-1:0] rgb_o
);
  localparam logic [CH_W-1:0] FULL = '1;
  localparam logic [CH_W-1:0] MID  = {1'b1, {(CH_W-1){1'b0}}};

  p_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_en_i |=> rgb_o == $past(vid_i));

  p_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_en_i && !de_i |=> rgb_o == '0);

  p_red_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_en_i && de_i && sel_r_i == 2'd3 |=> rgb_o[2*CH_W +: CH_W] == FULL);

  p_green_mid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_en_i && de_i && sel_g_i == 2'd2 |=> rgb_o[CH_W +: CH_W] == MID);

  p_blue_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_en_i && de_i && sel_b_i == 2'd1 |=> rgb_o[0 +: CH_W] == '0);

  p_line_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_en_i && de_i && hmode_i[1] && sel_r_i == 2'd0 && sel_g_i == 2'd0 && sel_b_i == 2'd0
    |=> (rgb_o[0 +: CH_W] == '0 || rgb_o[0 +: CH_W] == FULL) &&
        rgb_o[CH_W +: CH_W] == rgb_o[0 +: CH_W] &&
        rgb_o[2*CH_W +: CH_W] == rgb_o[0 +: CH_W]);
endmodule

bind grad_pattern_gen pg_checker #(.CH_W(CH_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pg_en_i (pg_en_i),
  .de_i    (de_i),
  .vid_i   (vid_i),
  .hmode_i (hmode_i),
  .sel_r_i (sel_r_i),
  .sel_g_i (sel_g_i),
  .sel_b_i (sel_b_i),
  .rgb_o   (rgb_o)
);

// File: tb/sim_grad_pattern_gen.sv
`timescale 1ns/1ps
module sim_grad_pattern_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pg_en_i = 1'b0, de_i = 1'b0, line_start_i = 1'b0, frame_start_i = 1'b0;
  logic [23:0] vid_i = '0;
  logic [15:0] init_i = '0, hinc_i = '0, vinc_i = '0;
  logic [7:0]  hstep_i = '0, vstep_i = '0;
  logic [1:0]  hmode_i = '0, vmode_i = '0;
  logic        hrep2_i = 1'b0, vrep2_i = 1'b0;
  logic [11:0] act_w_i = '0, act_h_i = '0;
  logic [1:0]  sel_r_i = '0, sel_g_i = '0, sel_b_i = '0;
  logic [23:0] rgb_o;

  int total = 0, bad = 0;
  int mx = 0, my = 0, mhad = 0;
  int vcnt = 0;

  always #5 clk_i = ~clk_i;

  grad_pattern_gen u0 (.*);

  function automatic logic [7:0] chan(input logic [1:0] s, input logic [15:0] v);
    case (s)
      2'd0: chan = v[15:8];
      2'd1: chan = 8'h00;
      2'd2: chan = 8'h80;
      default: chan = 8'hFF;
    endcase
  endfunction

  // reference: pixel from coordinates (R4..R10)
  function automatic logic [23:0] ref_px(input logic de);
    int xe, ye, hs, hp, vs, vp, hw, hh;
    logic [15:0] v;
    logic hl, vl;
    if (!pg_en_i) return vid_i;
    if (!de) return 24'h0;
    hw = int'(act_w_i) / 2;
    hh = int'(act_h_i) / 2;
    xe = (hrep2_i && mx >= hw) ? mx - hw : mx;
    ye = (vrep2_i && my >= hh) ? my - hh : my;
    hs = xe / (int'(hstep_i) + 1); hp = xe % (int'(hstep_i) + 1);
    vs = ye / (int'(vstep_i) + 1); vp = ye % (int'(vstep_i) + 1);
    hl = hmode_i >= 2; vl = vmode_i >= 2;
    if (hl || vl) begin
      v = ((hl && hp == 0) || (vl && vp == 0)) ? 16'hFFFF : 16'h0000;
    end else begin
      v = 16'(int'(init_i) + hs * int'(hinc_i) + vs * int'(vinc_i));
      if (hmode_i == 2'd1 && (hs % 2) == 1) v = ~v;
      if (vmode_i == 2'd1 && (vs % 2) == 1) v = ~v;
    end
    return {chan(sel_r_i, v), chan(sel_g_i, v), chan(sel_b_i, v)};
  endfunction

  task automatic check(input string tag, input logic [23:0] exp);
    total++;
    if (rgb_o !== exp) begin
      bad++;
      $display("FAIL %s: rgb_o=%06h expected=%06h", tag, rgb_o, exp);
    end
  endtask

  task automatic cyc(input logic de, input logic ls, input logic fs, input string tag);
    logic [23:0] exp;
    de_i = de; line_start_i = ls; frame_start_i = fs;
    vcnt++;
    vid_i = 24'(vcnt * 24'h0A1B3D);
    exp = ref_px(de);
    @(posedge clk_i);
    if (fs) begin mx = 0; my = 0; mhad = 0; end
    else if (ls) begin if (mhad != 0) my++; mhad = 0; mx = 0; end
    else if (de) begin mx++; mhad = 1; end
    #1;
    check((pg_en_i && !de) ? "R3" : tag, exp);
  endtask

  task automatic frame(input int nl, input int npx, input bit empty, input string tag);
    cyc(0, 0, 1, tag);
    for (int l = 0; l < nl; l++) begin
      if (empty && l == 2) begin
        cyc(0, 1, 0, tag); cyc(0, 0, 0, tag);
      end
      cyc(0, 1, 0, tag);
      cyc(0, 0, 0, tag);
      for (int p = 0; p < npx; p++) cyc(1, 0, 0, tag);
      cyc(0, 0, 0, tag);
    end
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: rgb_o=%06h expected=end of run", rgb_o);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vid_i = 24'h5A5A5A;
    #23;
    check("R1", 24'h0);
    @(negedge clk_i); check("R1", 24'h0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R2 pass-through with pattern controls set
    hmode_i = 2'd2; sel_r_i = 2'd3;
    frame(2, 4, 0, "R2");
    hmode_i = 2'd0; sel_r_i = 2'd0;

    // R4, R5 gradient
    pg_en_i = 1'b1;
    init_i = 16'h1234; hinc_i = 16'h0733; vinc_i = 16'h2100;
    hstep_i = 8'd2; vstep_i = 8'd1;
    act_w_i = 12'd9; act_h_i = 12'd5;
    frame(5, 9, 0, "R4,R5");
    hstep_i = 8'd0; vstep_i = 8'd0; hinc_i = 16'hF00F;
    frame(3, 6, 0, "R4,R5");

    // R6 empty line skipped, new frame restarts
    hstep_i = 8'd1;
    frame(4, 5, 1, "R6");
    frame(2, 5, 0, "R6");

    // R7 inversion
    hmode_i = 2'd1; vmode_i = 2'd0; frame(4, 8, 0, "R7");
    hmode_i = 2'd0; vmode_i = 2'd1; frame(4, 8, 0, "R7");
    hmode_i = 2'd1; vmode_i = 2'd1; frame(4, 8, 0, "R7");

    // R8 line modes
    hmode_i = 2'd2; vmode_i = 2'd0; hstep_i = 8'd2; frame(3, 8, 0, "R8");
    hmode_i = 2'd0; vmode_i = 2'd3; vstep_i = 8'd1; frame(4, 6, 0, "R8");
    hmode_i = 2'd3; vmode_i = 2'd2; frame(4, 7, 0, "R8");
    hmode_i = 2'd1; vmode_i = 2'd3; frame(3, 5, 0, "R8");

    // R9 repeat two
    hmode_i = 2'd0; vmode_i = 2'd0; hstep_i = 8'd1; vstep_i = 8'd0;
    hrep2_i = 1'b1; act_w_i = 12'd9; frame(2, 9, 0, "R9");
    hrep2_i = 1'b0; vrep2_i = 1'b1; act_h_i = 12'd4; frame(5, 4, 0, "R9");
    hrep2_i = 1'b1; act_w_i = 12'd6; act_h_i = 12'd5; frame(5, 6, 0, "R9");
    hrep2_i = 1'b0; vrep2_i = 1'b0;

    // R10 channel selects
    sel_r_i = 2'd1; sel_g_i = 2'd2; sel_b_i = 2'd3; frame(2, 4, 0, "R10");
    sel_r_i = 2'd3; sel_g_i = 2'd0; sel_b_i = 2'd2; frame(2, 4, 0, "R10");
    sel_r_i = 2'd0; sel_g_i = 2'd1; sel_b_i = 2'd0; frame(2, 4, 0, "R10");

    // R2 back to pass-through
    pg_en_i = 1'b0; frame(1, 3, 0, "R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule